// File: doc/BRIEF.md
# Volume Button Counter Register

This peripheral turns front-panel volume buttons into state that a host can read. Each volume-up or volume-down press moves two identical 3-bit saturating counters by one step. The counters are packed into a single byte. Every press also raises a level interrupt. A mute press raises the interrupt but does not move the counters, and it sets a separate mute flag. The host can then tell mute apart from a volume change.

The host reads the counter byte through any of four aliased addresses, all of which return the same value. A write of any data to any of these four addresses rearms both counters to their midpoint. The host can then measure the next change relative to that midpoint. A separate status address reports the interrupt and the mute flag. A write to the status address clears both. Button inputs arrive as single-cycle pulses that are already synchronized and debounced.

Top module: `volbtn_regs`

## Requirements
- R1: After reset, every alias address (0 to 3) reads 0x88, the status address (4) reads 0x00, and `irq` is low.
- R2: The counter byte holds counter A in bits 3:1 and counter B in bits 7:5, and bits 0 and 4 always read zero. Both counters always hold the same value, so one up press from the rearmed state reads 0xAA and one down press reads 0x66.
- R3: A volume-up press adds one to both counters. At 7 they stay at 7 (byte 0xEE) and never wrap.
- R4: A volume-down press subtracts one from both counters. At 0 they stay at 0 (byte 0x00) and never wrap.
- R5: A mute press leaves both counters unchanged and sets the mute flag.
- R6: When several button pulses arrive in the same cycle, mute wins over up and down, and up wins over down. The other pulses of that cycle are dropped.
- R7: Any press (up, down or mute) drives `irq` high one cycle later, in the same cycle the counters show the update. `irq` stays high until the host writes the status address. A press in the same cycle as that write leaves `irq` high. A write to an alias address does not affect `irq`.
- R8: A write of any data value to any alias address 0 to 3 sets both counters to 4 (byte 0x88) on the next cycle. This rearm wins over a button press in the same cycle.
- R9: Reads of addresses 0 to 3 return identical values. Addresses 5 to 7 read 0x00, and writes to them change no state.
- R10: The status address reads bit 0 = interrupt pending and bit 1 = mute flag, with the other bits zero. A write of any value to it clears both bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_pulse | input | 1 | Volume-up press, one-cycle pulse |
| down_pulse | input | 1 | Volume-down press, one-cycle pulse |
| mute_pulse | input | 1 | Mute press, one-cycle pulse |
| bus_addr | input | 3 | Register address for read and write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data (the value is ignored by every register) |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt, pending until cleared |

## Verification
A counter held in a wrong state shows on the very next read of any alias address. The two fields of the byte would then differ, sit at a wrong offset from 0x88, or show a set reserved bit. A saturation fault appears only after the counter has been driven to a limit and pushed once more, so the bench walks both counters fully to each end. A fault in the interrupt or mute-flag state appears on `irq` or the status byte one cycle after the press or clear. Clear and press are therefore applied in the same cycle to expose any ordering error.

// File: rtl/volbtn_pkg.sv
package volbtn_pkg;
  // One decoded button event per cycle, after priority resolution.
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_UP   = 2'd1,
    EV_DOWN = 2'd2,
    EV_MUTE = 2'd3
  } vol_ev_e;
endpackage

// File: rtl/volbtn_event.sv
module volbtn_event
  import volbtn_pkg::*;
(
  input  logic    up_pulse,
  input  logic    down_pulse,
  input  logic    mute_pulse,
  output vol_ev_e ev
);
  // Mute dominates, then up, then down.
  always_comb begin
    if (mute_pulse)      ev = EV_MUTE;
    else if (up_pulse)   ev = EV_UP;
    else if (down_pulse) ev = EV_DOWN;
    else                 ev = EV_NONE;
  end
endmodule

// File: rtl/volbtn_sat_cnt.sv
module volbtn_sat_cnt
  import volbtn_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm,
  input  vol_ev_e          ev,
  output logic [CNT_W-1:0] q
);
  localparam logic [CNT_W-1:0] MID_VAL = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic [CNT_W-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_d = q;
    if (rearm) begin
      q_d = MID_VAL;
    end else begin
      case (ev)
        EV_UP:   if (q != MAX_VAL) q_d = q + 1'b1;
        EV_DOWN: if (q != '0)      q_d = q - 1'b1;
        default: q_d = q;
      endcase
    end
  end

  assign q_en = rearm | (ev == EV_UP) | (ev == EV_DOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= MID_VAL;
    else if (q_en)  q <= q_d;
  end
endmodule

// File: rtl/volbtn_irq.sv
module volbtn_irq
  import volbtn_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  vol_ev_e ev,
  input  logic    clr,
  output logic    irq_q,
  output logic    mute_q
);
  logic irq_d;
  logic mute_d;
  logic upd_en;

  // A press in the clear cycle survives the clear.
  always_comb begin
    irq_d  = (ev != EV_NONE) | (irq_q & ~clr);
    mute_d = (ev == EV_MUTE) | (mute_q & ~clr);
  end

  assign upd_en = clr | (ev != EV_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      mute_q <= 1'b0;
    end else if (upd_en) begin
      irq_q  <= irq_d;
      mute_q <= mute_d;
    end
  end
endmodule

// File: rtl/volbtn_regs.sv
module volbtn_regs
  import volbtn_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int NUM_CNT   = 2,
  parameter int ADDR_W    = 3,
  parameter int N_ALIAS   = 4,
  parameter int STAT_ADDR = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           up_pulse,
  input  logic                           down_pulse,
  input  logic                           mute_pulse,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic [NUM_CNT*(CNT_W+1)-1:0]   bus_wdata,
  output logic [NUM_CNT*(CNT_W+1)-1:0]   bus_rdata,
  output logic                           irq
);
  localparam int                FIELD_W   = CNT_W + 1;
  localparam int                DATA_W    = NUM_CNT * FIELD_W;
  localparam logic [ADDR_W-1:0] ALIAS_LIM = ADDR_W'(N_ALIAS);
  localparam logic [ADDR_W-1:0] STAT_A    = ADDR_W'(STAT_ADDR);

  vol_ev_e                  ev;
  logic                     alias_hit;
  logic                     alias_wr;
  logic                     stat_wr;
  logic                     mute_seen;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [DATA_W-1:0]        cnt_byte;
  logic                     wdata_unused;

  // Every register ignores the write data.
  assign wdata_unused = ^bus_wdata;

  assign alias_hit = (bus_addr < ALIAS_LIM);
  assign alias_wr  = bus_wr & alias_hit;
  assign stat_wr   = bus_wr & (bus_addr == STAT_A);

  volbtn_event u_event (
    .up_pulse   (up_pulse),
    .down_pulse (down_pulse),
    .mute_pulse (mute_pulse),
    .ev         (ev)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic [CNT_W-1:0] q;
    volbtn_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .rearm (alias_wr),
      .ev    (ev),
      .q     (q)
    );
    assign cnt_flat[g*CNT_W +: CNT_W]   = q;
    // Counter in the upper bits of its field, reserved zero below it.
    assign cnt_byte[g*FIELD_W +: FIELD_W] = {q, 1'b0};
  end

  volbtn_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .clr    (stat_wr),
    .irq_q  (irq),
    .mute_q (mute_seen)
  );

  always_comb begin
    bus_rdata = '0;
    if (alias_hit) begin
      bus_rdata = cnt_byte;
    end else if (bus_addr == STAT_A) begin
      bus_rdata[1:0] = {mute_seen, irq};
    end
  end
endmodule

// File: rtl/volbtn_chk.sv
module volbtn_chk #(
  parameter int CNT_W   = 3,
  parameter int NUM_CNT = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     up_pulse,
  input logic                     down_pulse,
  input logic                     mute_pulse,
  input logic                     alias_wr,
  input logic                     stat_wr,
  input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  input logic                     irq
);
  localparam logic [CNT_W-1:0] MID_VAL = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
    logic [CNT_W-1:0] cur;
    assign cur = cnt_flat[g*CNT_W +: CNT_W];

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_pulse && !mute_pulse && !alias_wr && cur != MAX_VAL) |=> cur == CNT_W'($past(cur) + 1'b1));

    // R3
    up_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_pulse && !mute_pulse && !alias_wr && cur == MAX_VAL) |=> cur == MAX_VAL);

    // R4
    down_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (down_pulse && !up_pulse && !mute_pulse && !alias_wr && cur == '0) |=> cur == '0);

    // R2
    lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur == cnt_flat[CNT_W-1:0]);
  end

  // R5
  mute_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_pulse && !alias_wr) |=> cnt_flat == $past(cnt_flat));

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pulse || down_pulse || mute_pulse) |=> irq);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_wr) |=> irq);

  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alias_wr |=> cnt_flat == {NUM_CNT{MID_VAL}});
endmodule

bind volbtn_regs volbtn_chk #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .up_pulse   (up_pulse),
  .down_pulse (down_pulse),
  .mute_pulse (mute_pulse),
  .alias_wr   (alias_wr),
  .stat_wr    (stat_wr),
  .cnt_flat   (cnt_flat),
  .irq        (irq)
);

// File: tb/tb_volbtn_regs.sv
module tb_volbtn_regs;
  logic       clk;
  logic       rst_n;
  logic       up_pulse, down_pulse, mute_pulse;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;

  volbtn_regs dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_pulse   (up_pulse),
    .down_pulse (down_pulse),
    .mute_pulse (mute_pulse),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] byte_of(int c);
    logic [2:0] v;
    v = 3'(c);
    return {v, 1'b0, v, 1'b0};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic press(logic u, logic d, logic m);
    @(negedge clk);
    up_pulse = u; down_pulse = d; mute_pulse = m;
    @(negedge clk);
    up_pulse = 0; down_pulse = 0; mute_pulse = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d); chk("R1 alias after reset", d, 8'h88);
    end
    rd(3'd4, d); chk("R1 status after reset", d, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_single();
    logic [7:0] d;
    press(1, 0, 0);
    rd(3'd0, d); chk("R2 one up reads 0xAA", d, 8'hAA);
    chk("R7 irq after up", {7'd0, irq}, 8'h01);
    wr(3'd2, 8'h00);
    rd(3'd0, d); chk("R8 rearm via addr 2 with data 0", d, 8'h88);
    wr(3'd4, 8'h5A);
    press(0, 1, 0);
    rd(3'd3, d); chk("R2 one down reads 0x66", d, 8'h66);
    chk("R7 irq after down", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_sat_up();
    logic [7:0] d;
    wr(3'd1, 8'hFF);
    for (int i = 0; i < 6; i++) press(1, 0, 0);
    rd(3'd1, d); chk("R3 saturate at top", d, 8'hEE);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_sat_down();
    logic [7:0] d;
    wr(3'd0, 8'h13);
    for (int i = 0; i < 6; i++) press(0, 1, 0);
    rd(3'd2, d); chk("R4 saturate at bottom", d, 8'h00);
    press(1, 0, 0);
    rd(3'd2, d); chk("R4 no wrap, then up", d, byte_of(1));
    wr(3'd4, 8'h00);
  endtask

  task automatic t_mute();
    logic [7:0] d;
    wr(3'd0, 8'h00);
    press(1, 0, 0);
    wr(3'd4, 8'h00);
    press(0, 0, 1);
    rd(3'd0, d); chk("R5 mute keeps counters", d, 8'hAA);
    rd(3'd4, d); chk("R10 status after mute", d, 8'h03);
    wr(3'd4, 8'hFF);
    rd(3'd4, d); chk("R10 status cleared", d, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(3'd0, 8'h00);
    press(1, 1, 1);
    rd(3'd0, d); chk("R6 mute beats up and down", d, 8'h88);
    rd(3'd4, d); chk("R6 mute flag on combined press", d, 8'h03);
    wr(3'd4, 8'h00);
    press(1, 1, 0);
    rd(3'd0, d); chk("R6 up beats down", d, 8'hAA);
    // rearm and up press in the same cycle
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 8'h77; bus_wr = 1; up_pulse = 1;
    @(negedge clk);
    bus_wr = 0; up_pulse = 0;
    rd(3'd0, d); chk("R8 rearm wins over press", d, 8'h88);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    press(0, 1, 0);
    repeat (5) @(negedge clk);
    chk("R7 irq held", {7'd0, irq}, 8'h01);
    wr(3'd1, 8'h00);
    chk("R7 alias write keeps irq", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h00);
    chk("R7 status write clears irq", {7'd0, irq}, 8'h00);
    @(negedge clk);
    bus_addr = 3'd4; bus_wr = 1; up_pulse = 1;
    @(negedge clk);
    bus_wr = 0; up_pulse = 0;
    chk("R7 press in clear cycle keeps irq", {7'd0, irq}, 8'h01);
    rd(3'd4, d); chk("R10 status irq only", d, 8'h01);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    wr(3'd0, 8'h00);
    press(1, 0, 0);
    wr(3'd4, 8'h00);
    for (int a = 5; a < 8; a++) wr(3'(a), 8'hFF);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d); chk("R9 aliases equal, unused writes ignored", d, 8'hAA);
    end
    rd(3'd6, d); chk("R9 unused address reads zero", d, 8'h00);
    chk("R9 unused write leaves irq", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    rst_n = 0; up_pulse = 0; down_pulse = 0; mute_pulse = 0;
    bus_addr = 0; bus_wr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_sat_up();
    t_sat_down();
    t_mute();
    t_priority();
    t_irq();
    t_unused();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule